// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run in parallel. The first is an address-only table of 2-bit saturating counters. The second is a correlating table: each address entry holds one 2-bit counter for every pattern of the recent global outcome history. A third table of 2-bit counters, also indexed by branch address, holds one selector per entry. The selector decides which component's guess becomes the final prediction.

The fetch side presents a branch address on the predict port. In the same cycle it receives the final direction, the guess of each component and the selector's choice. The execute side reports each resolved branch on the update port with its address and real outcome. That report trains all three tables and shifts the outcome into the global history. Updates are non-speculative, and target prediction is handled elsewhere.

Top module: `tbp_top`

## Requirements
- R1: After reset, every counter in the address-only and correlating tables holds 01 (weakly not taken). Every selector holds 01. The global history is 00. So every address predicts not taken, and the address-only component is chosen.
- R2: Every 2-bit counter saturates at 00 and 11 and steps one place per update: up on a taken outcome, down on a not-taken outcome. Values 10 and 11 mean taken, and 00 and 01 mean not taken. A strongly biased counter flips its direction only after two consecutive opposite outcomes.
- R3: The address-only table and the selector table are indexed by branch address bits [7:2] (64 entries). Two addresses that agree in those bits share an entry.
- R4: On every update the history shifts left by one and the outcome enters bit 0. History 01 therefore means the older branch was not taken and the newer one was taken. The history is visible on `histOut`.
- R5: The correlating table is indexed by address bits [5:2] (16 entries). The current history picks one of four counters in that entry. Only that counter is trained by an update, using the history value from before the shift.
- R6: A selector value of 10 or 11 chooses the correlating component, and 00 or 01 chooses the address-only component. A selector changes only when the two components disagree at the updated address. It then steps toward the correlating side if that component was right, and toward the address-only side otherwise.
- R7: While `updValid` is low, the values on `updPc` and `updTaken` have no effect on any table or on the history.
- R8: Predictions are combinational from `predPc` and the current state. An update takes effect from the following cycle, so a prediction in the same cycle as an update to the same address sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predPc | input | 32 | Branch address to predict |
| predTaken | output | 1 | Final predicted direction (1 = taken) |
| predLocal | output | 1 | Address-only component's guess |
| predCorr | output | 1 | Correlating component's guess under the current history |
| predUseCorr | output | 1 | Selector chose the correlating component |
| updValid | input | 1 | A resolved branch is reported this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Real outcome of the resolved branch |
| histOut | output | 2 | Current global outcome history, newest in bit 0 |

## Verification
The assertions check four things on every cycle. The history shifts correctly on each update and holds without one. All outputs stay steady while the address and state stay steady. An address-only counter whose guess was confirmed keeps its direction. A selector at an address where both components agreed does not move. Two further matters need the bench's scenarios, which compare every output against a bench-side arithmetic model. The first is how a counter takes two mispredictions to flip. The second is which of the four correlating counters a given history trains, along with table aliasing and the selector drifting toward the component that wins on alternating patterns.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  // Update strobes from control to datapath
  typedef struct packed {
    logic localWe;
    logic localUp;
    logic corrWe;
    logic corrUp;
    logic selWe;
    logic selUp;
    logic histShift;
    logic histBit;
  } tbp_strobe_t;

  // Saturating step of a 2-bit counter
  function automatic ctr_t ctrStep(ctr_t c, logic up);
    ctr_t n;
    if (up) n = (c == 2'b11) ? c : c + 2'b01;
    else    n = (c == 2'b00) ? c : c - 2'b01;
    return n;
  endfunction

  function automatic logic ctrTaken(ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrUp,
  output ctr_t             rdA,
  output ctr_t             rdB
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];

  assign rdA = tbl[rdIdxA];
  assign rdB = tbl[rdIdxB];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_NT;
    end else if (wrEn) begin
      tbl[wrIdx] <= ctrStep(tbl[wrIdx], wrUp);
    end
  end
endmodule

// File: rtl/tbp_datapath.sv
module tbp_datapath
  import tbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ALIGN  = 2,
  parameter int LIDX_W = 6,
  parameter int CIDX_W = 4,
  parameter int SIDX_W = 6,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  input  logic [PC_W-1:0]   updPc,
  input  tbp_strobe_t       strobe,
  output ctr_t              predLocalCtr,
  output ctr_t              predCorrCtr,
  output ctr_t              predSelCtr,
  output ctr_t              updLocalCtr,
  output ctr_t              updCorrCtr,
  output logic [HIST_W-1:0] hist
);
  localparam int MAXW0  = (LIDX_W > CIDX_W) ? LIDX_W : CIDX_W;
  localparam int MAXW   = (MAXW0 > SIDX_W) ? MAXW0 : SIDX_W;
  localparam int CFLAT_W = CIDX_W + HIST_W;

  // Address bits no table looks at
  logic unusedPcBits;
  assign unusedPcBits = ^{predPc[PC_W-1:ALIGN+MAXW], predPc[ALIGN-1:0],
                          updPc[PC_W-1:ALIGN+MAXW], updPc[ALIGN-1:0]};

  logic [LIDX_W-1:0]  pLIdx, uLIdx;
  logic [SIDX_W-1:0]  pSIdx, uSIdx;
  logic [CFLAT_W-1:0] pCIdx, uCIdx;
  ctr_t               updSelUnused;

  assign pLIdx = predPc[ALIGN +: LIDX_W];
  assign uLIdx = updPc[ALIGN +: LIDX_W];
  assign pSIdx = predPc[ALIGN +: SIDX_W];
  assign uSIdx = updPc[ALIGN +: SIDX_W];
  // history picks the counter inside an address entry
  assign pCIdx = {predPc[ALIGN +: CIDX_W], hist};
  assign uCIdx = {updPc[ALIGN +: CIDX_W], hist};

  tbp_ctr_table #(.IDX_W(LIDX_W)) u_localTbl (
    .clk(clk), .rstN(rstN),
    .rdIdxA(pLIdx), .rdIdxB(uLIdx),
    .wrEn(strobe.localWe), .wrIdx(uLIdx), .wrUp(strobe.localUp),
    .rdA(predLocalCtr), .rdB(updLocalCtr)
  );

  tbp_ctr_table #(.IDX_W(CFLAT_W)) u_corrTbl (
    .clk(clk), .rstN(rstN),
    .rdIdxA(pCIdx), .rdIdxB(uCIdx),
    .wrEn(strobe.corrWe), .wrIdx(uCIdx), .wrUp(strobe.corrUp),
    .rdA(predCorrCtr), .rdB(updCorrCtr)
  );

  tbp_ctr_table #(.IDX_W(SIDX_W)) u_selTbl (
    .clk(clk), .rstN(rstN),
    .rdIdxA(pSIdx), .rdIdxB(uSIdx),
    .wrEn(strobe.selWe), .wrIdx(uSIdx), .wrUp(strobe.selUp),
    .rdA(predSelCtr), .rdB(updSelUnused)
  );

  always_ff @(posedge clk) begin
    if (!rstN) hist <= '0;
    else if (strobe.histShift) hist <= HIST_W'({hist, strobe.histBit});
  end
endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
  import tbp_pkg::*;
(
  input  logic        updValid,
  input  logic        updTaken,
  input  ctr_t        updLocalCtr,
  input  ctr_t        updCorrCtr,
  input  ctr_t        predLocalCtr,
  input  ctr_t        predCorrCtr,
  input  ctr_t        predSelCtr,
  output tbp_strobe_t strobe,
  output logic        predTaken,
  output logic        predLocal,
  output logic        predCorr,
  output logic        predUseCorr
);
  logic uLocalDir, uCorrDir;

  assign uLocalDir = ctrTaken(updLocalCtr);
  assign uCorrDir  = ctrTaken(updCorrCtr);

  always_comb begin
    strobe           = '0;
    strobe.localWe   = updValid;
    strobe.localUp   = updTaken;
    strobe.corrWe    = updValid;
    strobe.corrUp    = updTaken;
    // selector trains only on disagreement
    strobe.selWe     = updValid && (uLocalDir != uCorrDir);
    strobe.selUp     = (uCorrDir == updTaken);
    strobe.histShift = updValid;
    strobe.histBit   = updTaken;
  end

  assign predLocal   = ctrTaken(predLocalCtr);
  assign predCorr    = ctrTaken(predCorrCtr);
  assign predUseCorr = ctrTaken(predSelCtr);
  assign predTaken   = predUseCorr ? predCorr : predLocal;
endmodule

// File: rtl/tbp_top.sv
module tbp_top
  import tbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ALIGN  = 2,
  parameter int LIDX_W = 6,
  parameter int CIDX_W = 4,
  parameter int SIDX_W = 6,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  output logic              predTaken,
  output logic              predLocal,
  output logic              predCorr,
  output logic              predUseCorr,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updTaken,
  output logic [HIST_W-1:0] histOut
);
  tbp_strobe_t strobe;
  ctr_t predLocalCtr, predCorrCtr, predSelCtr;
  ctr_t updLocalCtr, updCorrCtr;

  tbp_datapath #(
    .PC_W(PC_W), .ALIGN(ALIGN), .LIDX_W(LIDX_W),
    .CIDX_W(CIDX_W), .SIDX_W(SIDX_W), .HIST_W(HIST_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .predPc(predPc), .updPc(updPc), .strobe(strobe),
    .predLocalCtr(predLocalCtr), .predCorrCtr(predCorrCtr), .predSelCtr(predSelCtr),
    .updLocalCtr(updLocalCtr), .updCorrCtr(updCorrCtr), .hist(histOut)
  );

  tbp_ctrl u_ctrl (
    .updValid(updValid), .updTaken(updTaken),
    .updLocalCtr(updLocalCtr), .updCorrCtr(updCorrCtr),
    .predLocalCtr(predLocalCtr), .predCorrCtr(predCorrCtr), .predSelCtr(predSelCtr),
    .strobe(strobe), .predTaken(predTaken), .predLocal(predLocal),
    .predCorr(predCorr), .predUseCorr(predUseCorr)
  );
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   predPc,
  input logic              predTaken,
  input logic              predLocal,
  input logic              predCorr,
  input logic              predUseCorr,
  input logic              updValid,
  input logic [PC_W-1:0]   updPc,
  input logic              updTaken,
  input logic [HIST_W-1:0] histOut
);
  // R4: outcome enters the history on each update
  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> histOut == HIST_W'({$past(histOut), $past(updTaken)}));

  // R7: no update, no history change
  p_idle_hist_r7: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histOut));

  // R8: steady address and no update keeps every output steady
  p_steady_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> (predPc != $past(predPc)) ||
                  ($stable(predTaken) && $stable(predLocal) &&
                   $stable(predCorr) && $stable(predUseCorr)));

  // R2: a confirmed address-only guess keeps its direction
  p_local_confirm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updPc == predPc && predLocal == updTaken) |=>
      (predPc != $past(predPc)) || (predLocal == $past(updTaken)));

  // R6: selector holds when both components agree
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updPc == predPc && predLocal == predCorr) |=>
      (predPc != $past(predPc)) || (predUseCorr == $past(predUseCorr)));
endmodule

bind tbp_top tbp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) u_tbpChecker (
  .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
  .predLocal(predLocal), .predCorr(predCorr), .predUseCorr(predUseCorr),
  .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .histOut(histOut)
);

// File: tb/tbp_top_bench.sv
`timescale 1ns/1ps
module tbp_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] predPc = '0;
  logic        predTaken, predLocal, predCorr, predUseCorr;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updTaken = 1'b0;
  logic [1:0]  histOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tbp_top #(.PC_W(32), .ALIGN(2), .LIDX_W(6), .CIDX_W(4), .SIDX_W(6), .HIST_W(2)) u_tbp_top (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .predLocal(predLocal), .predCorr(predCorr), .predUseCorr(predUseCorr),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .histOut(histOut)
  );

  // Arithmetic model built from the requirements
  logic [1:0] mLocal [64];
  logic [1:0] mCorr  [64];
  logic [1:0] mSel   [64];
  logic [1:0] mHist;

  function automatic logic [1:0] step(logic [1:0] c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 64; i++) begin
      mLocal[i] = 2'b01; mCorr[i] = 2'b01; mSel[i] = 2'b01;
    end
    mHist = 2'b00;
  endtask

  task automatic modelUpdate(input logic [31:0] pc, input logic t);
    int li, ci;
    logic lp, cp;
    li = pc[7:2];
    ci = {pc[5:2], mHist};
    lp = mLocal[li][1];
    cp = mCorr[ci][1];
    if (lp != cp) mSel[li] = step(mSel[li], cp == t);
    mLocal[li] = step(mLocal[li], t);
    mCorr[ci]  = step(mCorr[ci], t);
    mHist      = {mHist[0], t};
  endtask

  task automatic cmp(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareNow(input logic [31:0] pc, input string tag);
    logic eL, eC, eS;
    eL = mLocal[pc[7:2]][1];
    eC = mCorr[{pc[5:2], mHist}][1];
    eS = mSel[pc[7:2]][1];
    cmp(tag, "predLocal", {1'b0, predLocal}, {1'b0, eL});
    cmp(tag, "predCorr", {1'b0, predCorr}, {1'b0, eC});
    cmp(tag, "predUseCorr", {1'b0, predUseCorr}, {1'b0, eS});
    cmp(tag, "predTaken", {1'b0, predTaken}, {1'b0, eS ? eC : eL});
    cmp(tag, "histOut", histOut, mHist);
  endtask

  task automatic checkAt(input logic [31:0] pc, input string tag);
    @(negedge clk);
    predPc = pc;
    #1;
    compareNow(pc, tag);
  endtask

  task automatic doUpdate(input logic [31:0] pc, input logic t);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = t;
    @(posedge clk);
    #1;
    modelUpdate(pc, t);
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic updCheck(input logic [31:0] pc, input logic t, input string tag);
    doUpdate(pc, t);
    checkAt(pc, tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state over every address-only/selector entry
    for (int i = 0; i < 64; i++) checkAt(32'(i << 2), "R1");

    // R2: hysteresis on one address
    updCheck(32'h10, 1'b1, "R2");
    updCheck(32'h10, 1'b1, "R2");
    updCheck(32'h10, 1'b1, "R2");
    updCheck(32'h10, 1'b0, "R2");
    checks++;
    if (predLocal !== 1'b1) begin errors++;
      $display("FAIL R2 one miss flipped actual=%0d expected=1", predLocal); end
    updCheck(32'h10, 1'b0, "R2");
    checks++;
    if (predLocal !== 1'b0) begin errors++;
      $display("FAIL R2 two misses no flip actual=%0d expected=0", predLocal); end

    // R4: history order
    doUpdate(32'h14, 1'b0);
    doUpdate(32'h14, 1'b1);
    @(negedge clk); #1;
    cmp("R4", "histOut explicit", histOut, 2'b01);

    // R3: aliasing of address-only entries (0x44 and 0x144)
    updCheck(32'h44, 1'b1, "R3");
    updCheck(32'h44, 1'b1, "R3");
    checkAt(32'h144, "R3");
    checks++;
    if (predLocal !== 1'b1) begin errors++;
      $display("FAIL R3 alias not shared actual=%0d expected=1", predLocal); end

    // R5: repeating pattern trains the correlating counters
    for (int k = 0; k < 12; k++) updCheck(32'h20, (k % 4) < 2, "R5");

    // R6: alternating outcome favours the correlating side
    for (int k = 0; k < 16; k++) updCheck(32'h30, k[0], "R6");
    checks++;
    if (predUseCorr !== 1'b1) begin errors++;
      $display("FAIL R6 selector actual=%0d expected=1", predUseCorr); end

    // R7: idle update port has no effect
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      updValid = 1'b0; updPc = 32'(k * 4 + 16'h30); updTaken = k[0];
    end
    for (int i = 0; i < 64; i++) checkAt(32'(i << 2), "R7");

    // R8: same-cycle predict sees old state, next cycle new
    @(negedge clk);
    predPc = 32'h3c; updValid = 1'b1; updPc = 32'h3c; updTaken = 1'b1;
    #1;
    compareNow(32'h3c, "R8");
    @(posedge clk); #1;
    modelUpdate(32'h3c, 1'b1);
    @(negedge clk);
    updValid = 1'b0;
    #1;
    compareNow(32'h3c, "R8");

    // R5 R6: pseudo-random sweep
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      updCheck(32'({lfsr[3:0], 2'b00}) | (lfsr[6] ? 32'h100 : 32'h0),
               lfsr[9] ^ (lfsr[3:0] < 4'd5), "R5 R6");
    end
    for (int i = 0; i < 64; i++) checkAt(32'(i << 2), "R3 R5");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule